// File: doc/BRIEF.md
# Masked Packed-Lane Logical AND Unit

This execution unit performs a bitwise AND on 64-bit lanes of two 512-bit sources and returns a 512-bit result one clock after the request. It works on raw bits. It does no floating-point interpretation, handles no NaN or denormal values and raises no exception flags. The old destination value comes in alongside the sources. Three things can come from it: the first operand in the two-operand form, the kept lanes under merge masking, and the untouched upper bits in the two-operand form.

A 2-bit form code chooses the encoding behaviour. Code 00 is the two-operand form, which works on exactly 128 bits. Code 01 is the unmasked three-operand form. Code 10 is the masked three-operand form, which adds a per-lane write mask, a merge-or-zero policy and a 64-bit broadcast of the second source. A 2-bit length code selects 128, 256 or 512 active bits. Its fourth value is reserved and flags the request as illegal.

Top module: `vlane_and_unit`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high and is low otherwise. `result` changes only on an accepted request and holds between requests. A synchronous active-high `rst` clears `out_valid`, `illegal` and `result`.
- R2: For form 01, and for form 11, which behaves the same way, each lane j below the active lane count gives `src_a` lane AND `src_b` lane. Lane j covers bits 64*j+63 down to 64*j. The length codes 00, 01 and 10 give 2, 4 and 8 lanes. The mask, `mask_en`, `zero_mode` and the broadcast flags have no effect in these forms.
- R3: In forms 01, 10 and 11, every result bit at or above the active length is zero.
- R4: Form 00 computes `old_dst` AND `src_b` over bits 127:0 only and passes `old_dst` bits 511:128 through unchanged. It does this for length codes 00, 01 and 10, and the mask and broadcast controls do not affect it.
- R5: In form 10 with `mask_en` high, an active lane whose mask bit is 1 gives `src_a` lane AND the second operand for that lane.
- R6: In form 10 with `mask_en` high and `zero_mode` low, an active lane whose mask bit is 0 keeps the `old_dst` lane.
- R7: In form 10 with `mask_en` high and `zero_mode` high, an active lane whose mask bit is 0 is all zeros.
- R8: In form 10, when `bcast` and `b_is_mem` are both high, every computed lane uses `src_b[63:0]` as its second operand. If either flag is low, each lane uses its own `src_b` lane.
- R9: In form 10 with `mask_en` low, every active lane is computed, whatever `lane_mask` holds.
- R10: Mask bits for lanes at or above the active lane count have no effect. Those lanes follow R3.
- R11: Length code 11 in any form gives an all-zero result, and `illegal` is high for that single output cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| form | input | 2 | 00 two-operand, 01 unmasked, 10 masked, 11 as 01 |
| vlen | input | 2 | 00=128, 01=256, 10=512 bits, 11 reserved |
| src_a | input | 512 | First source (three-operand forms) |
| src_b | input | 512 | Second source |
| old_dst | input | 512 | Prior destination value |
| lane_mask | input | 8 | Per-lane write mask, bit j for lane j |
| mask_en | input | 1 | Masking in use (form 10) |
| zero_mode | input | 1 | 1 zeroes unselected lanes, 0 merges them |
| bcast | input | 1 | Broadcast requested |
| b_is_mem | input | 1 | Second source comes from memory |
| out_valid | output | 1 | Result valid |
| illegal | output | 1 | Reserved length seen |
| result | output | 512 | Registered result |

## Verification
The assertions check on every cycle the one-cycle valid timing, the pairing of `illegal` with an all-zero valid result, the cleared upper bits for the shorter lengths in the three-operand forms, the pass-through of the upper 384 bits in the two-operand form, and lane 0 of the unmasked form. Other behaviours depend on several controls acting together, so only the bench scenarios can show them. These are merge versus zero on lanes that are not selected, broadcast taking effect only when it comes from memory, `mask_en` low overriding a zero mask, and mask bits above the lane count having no effect. The bench compares each of these, and a long run of random requests, against its behavioural model on every clock.

// File: rtl/vlane_and_unit.sv
module vlane_and_unit #(
  parameter int LANE_W = 64,
  parameter int LANES  = 8,
  localparam int W     = LANE_W * LANES,
  localparam int CW    = $clog2(LANES) + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       form,
  input  logic [1:0]       vlen,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic [W-1:0]     old_dst,
  input  logic [LANES-1:0] lane_mask,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic             bcast,
  input  logic             b_is_mem,
  output logic             out_valid,
  output logic             illegal,
  output logic [W-1:0]     result
);

  logic          is_leg, is_msk, rsvd, bc_eff;
  logic [CW-1:0] n_act;
  logic [W-1:0]  nxt;

  assign is_leg = (form == 2'b00);
  assign is_msk = (form == 2'b10);
  assign rsvd   = (vlen == 2'b11);
  assign bc_eff = is_msk & bcast & b_is_mem;

  always_comb begin
    if (is_leg) n_act = CW'(2);
    else begin
      case (vlen)
        2'b00:   n_act = CW'(2);
        2'b01:   n_act = CW'(4);
        default: n_act = CW'(8);
      endcase
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, o_l;
    logic              in_len, wr;
    assign o_l    = old_dst[j*LANE_W +: LANE_W];
    assign a_l    = is_leg ? o_l : src_a[j*LANE_W +: LANE_W];
    assign b_l    = bc_eff ? src_b[LANE_W-1:0] : src_b[j*LANE_W +: LANE_W];
    assign in_len = (CW'(j) < n_act);
    assign wr     = !is_msk | !mask_en | lane_mask[j];
    assign nxt[j*LANE_W +: LANE_W] =
        rsvd    ? '0 :
        !in_len ? (is_leg ? o_l : '0) :
        wr      ? (a_l & b_l) :
        zero_mode ? '0 : o_l;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid & rsvd;
      if (in_valid) result <= nxt;
    end
  end

endmodule

module vlane_and_chk #(
  parameter int LANE_W = 64,
  parameter int LANES  = 8,
  localparam int W     = LANE_W * LANES
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       form,
  input logic [1:0]       vlen,
  input logic [W-1:0]     src_a,
  input logic [W-1:0]     src_b,
  input logic [W-1:0]     old_dst,
  input logic [LANES-1:0] lane_mask,
  input logic             mask_en,
  input logic             zero_mode,
  input logic             bcast,
  input logic             b_is_mem,
  input logic             out_valid,
  input logic             illegal,
  input logic [W-1:0]     result
);

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(result));
  p_illegal_zero_r11: assert property (@(posedge clk) disable iff (rst)
    illegal |-> out_valid && result == '0);
  p_illegal_src_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid && vlen == 2'b11 |=> illegal);
  p_upper128_zero_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && form != 2'b00 && vlen == 2'b00 |=> result[W-1:128] == '0);
  p_upper256_zero_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && form != 2'b00 && vlen == 2'b01 |=> result[W-1:256] == '0);
  p_leg_pass_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && form == 2'b00 && vlen != 2'b11 |=> result[W-1:128] == $past(old_dst[W-1:128]));
  p_unmasked_lane0_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && form == 2'b01 && vlen != 2'b11 |=>
      result[LANE_W-1:0] == ($past(src_a[LANE_W-1:0]) & $past(src_b[LANE_W-1:0])));

endmodule

bind vlane_and_unit vlane_and_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/sim_vlane_and_unit.sv
`timescale 1ns/1ps
module sim_vlane_and_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   form = 2'b00, vlen = 2'b00;
  logic [511:0] src_a = '0, src_b = '0, old_dst = '0;
  logic [7:0]   lane_mask = '0;
  logic         mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0, b_is_mem = 1'b0;
  logic         out_valid, illegal;
  logic [511:0] result;

  int vectors = 0, errors = 0;
  logic [511:0] held = '0;

  always #2 clk = ~clk;

  vlane_and_unit u0 (.*);

  function automatic logic [511:0] model();
    logic [511:0] r;
    logic [63:0]  bl;
    int nl;
    r = '0;
    if (vlen == 2'b11) return r;
    if (form == 2'b00) begin
      r = old_dst;
      r[127:0] = old_dst[127:0] & src_b[127:0];
      return r;
    end
    nl = (vlen == 2'b00) ? 2 : (vlen == 2'b01) ? 4 : 8;
    for (int j = 0; j < nl; j++) begin
      bl = (form == 2'b10 && bcast && b_is_mem) ? src_b[63:0] : src_b[64*j +: 64];
      if (form != 2'b10 || !mask_en || lane_mask[j])
        r[64*j +: 64] = src_a[64*j +: 64] & bl;
      else if (!zero_mode)
        r[64*j +: 64] = old_dst[64*j +: 64];
    end
    return r;
  endfunction

  task automatic cmp(string tag, logic ev, logic ei, logic [511:0] er);
    vectors++;
    if (out_valid !== ev || illegal !== ei || result !== er) begin
      errors++;
      $display("FAIL %s: valid=%b illegal=%b result=%h expected valid=%b illegal=%b result=%h",
               tag, out_valid, illegal, result, ev, ei, er);
    end
  endtask

  task automatic fire(string tag);
    logic [511:0] e;
    logic ei;
    e  = model();
    ei = (vlen == 2'b11);
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    cmp(tag, 1'b1, ei, e);
    held = e;
  endtask

  task automatic idle(string tag);
    in_valid = 1'b0;
    @(posedge clk); #1;
    cmp(tag, 1'b0, 1'b0, held);
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic load_rand();
    src_a = rnd512(); src_b = rnd512(); old_dst = rnd512();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    cmp("R1 reset", 1'b0, 1'b0, '0);
    idle("R1 idle after reset");

    load_rand(); form = 2'b01; vlen = 2'b10; lane_mask = 8'h00; mask_en = 1'b1;
    zero_mode = 1'b1; bcast = 1'b1; b_is_mem = 1'b1;
    fire("R2 unmasked 512 controls ignored");
    idle("R1 result holds");
    load_rand(); form = 2'b11; fire("R2 form 11 as unmasked");

    load_rand(); form = 2'b01; vlen = 2'b00; fire("R3 unmasked 128 upper zero");
    load_rand(); vlen = 2'b01; fire("R3 unmasked 256 upper zero");
    load_rand(); form = 2'b10; vlen = 2'b00; mask_en = 1'b0; fire("R3 masked 128 upper zero");

    load_rand(); form = 2'b00; vlen = 2'b10; lane_mask = 8'h01; mask_en = 1'b1;
    zero_mode = 1'b1; bcast = 1'b1; b_is_mem = 1'b1;
    fire("R4 legacy 512 treated as 128");
    load_rand(); vlen = 2'b01; fire("R4 legacy 256");

    load_rand(); form = 2'b10; vlen = 2'b10; lane_mask = 8'hA5; mask_en = 1'b1;
    zero_mode = 1'b0; bcast = 1'b0; b_is_mem = 1'b0;
    fire("R5 R6 masked merge");
    load_rand(); zero_mode = 1'b1; fire("R5 R7 masked zero");
    load_rand(); lane_mask = 8'h00; zero_mode = 1'b0; fire("R6 all merged");

    load_rand(); lane_mask = 8'h3C; bcast = 1'b1; b_is_mem = 1'b1; fire("R8 broadcast from memory");
    load_rand(); b_is_mem = 1'b0; fire("R8 broadcast without memory");
    load_rand(); bcast = 1'b0; b_is_mem = 1'b1; fire("R8 memory without broadcast");

    load_rand(); lane_mask = 8'h00; mask_en = 1'b0; fire("R9 mask disabled writes all");

    load_rand(); vlen = 2'b00; lane_mask = 8'hFC; mask_en = 1'b1; zero_mode = 1'b0;
    fire("R10 mask above 128 ignored");
    load_rand(); vlen = 2'b01; lane_mask = 8'hF0; fire("R10 mask above 256 ignored");

    load_rand(); vlen = 2'b11; fire("R11 reserved length masked");
    idle("R11 illegal drops");
    load_rand(); form = 2'b00; fire("R11 reserved length legacy");
    load_rand(); form = 2'b01; vlen = 2'b10; fire("R11 clear after legal");

    for (int n = 0; n < 300; n++) begin
      string tag;
      load_rand();
      form = 2'($urandom); vlen = 2'($urandom); lane_mask = 8'($urandom);
      mask_en = 1'($urandom); zero_mode = 1'($urandom);
      bcast = 1'($urandom); b_is_mem = 1'($urandom);
      tag = (vlen == 2'b11) ? "R11 random" : (form == 2'b00) ? "R4 random" :
            (form == 2'b10) ? "R5 random masked" : "R2 random";
      fire(tag);
      if (n % 7 == 0) idle("R1 random idle");
    end

    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    held = '0;
    cmp("R1 reset mid-run", 1'b0, 1'b0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule